// File: doc/BRIEF.md
# Banked GPIO Controller

This block controls a bank of general-purpose pins. The pin count is a parameter and must be a multiple of 32; 64 and 96 are the intended sizes. Software reaches the bank through a plain 32-bit word-addressed read/write port. Each pin has a direction bit, an output value and a two-bit function code. The output value changes only through dedicated set and clear words.

The pin inputs pass through a two-flop synchronizer. Software can read the synchronized levels. Each pin has its own enables for rising and falling transitions. An enabled transition latches a sticky status bit, and software clears that bit by writing a one to it. A single interrupt line stays high while any status bit is set.

The registers are grouped by feature. Each group spans as many words as the pin count needs, so every address moves with the pin count. Pads connect through separate input, output and output-enable vectors. The function codes go out on their own vector for the pad multiplexer.

Top module: `gpio_bank`

## Requirements
- R1: After reset, pin_oe_o, pin_o, alt_fn_o, all edge status bits, the edge enables and irq_o are zero.
- R2: With K = pins/32, the word address of feature group g for pin p is g*K + p/32, and the bit within that word is p%32. The groups in order are: 0 level, 1 direction, 2 set, 3 clear, 4 rise enable, 5 fall enable, 6 edge status. The function-code group starts at word 7*K and takes 2*K words. Read data appears on rdata_o in the cycle after the request and holds until the next read. Unmapped addresses read as zero.
- R3: A direction bit of 1 drives that pin's pin_oe_o bit high (output). A bit of 0 leaves the pin as an input. pin_oe_o changes only on a write.
- R4: Writing a 1 to bit b of a set word drives the matching pin_o bit to 1. Writing a 1 to bit b of a clear word drives it to 0. Zero bits in either word leave pin_o unchanged.
- R5: A read of a level word returns pin_i after a two-flop synchronizer. A change on pin_i becomes visible to a read issued on the third clock edge after the change, and not to reads on the first two edges.
- R6: A pin's status bit is set on a 0-to-1 change of its synchronized level when its rise enable is 1, and on a 1-to-0 change when its fall enable is 1. Both enables may be set at once. Changes on pins without the matching enable set no status bit.
- R7: A status bit stays set until a write puts a 1 in its position of a status word. If an enabled edge arrives in the same cycle as that clear, the bit remains set.
- R8: The function code of pin p is two bits, at bits 2*(p%16)+1:2*(p%16) of function word p/16. It is output at alt_fn_o[2p+1:2p]. Code 0 means plain GPIO.
- R9: irq_o is high exactly while at least one status bit is set. irq_o does not rise while pin_i is held steady.
- R10: Writes to the level words have no effect, and reads of the set and clear words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pin_i | input | NUM_PINS | Pad input levels |
| pin_o | output | NUM_PINS | Pad output values |
| pin_oe_o | output | NUM_PINS | Pad output enables |
| alt_fn_o | output | 2*NUM_PINS | Function code per pin |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
Set and clear words are written in overlapping and disjoint patterns. This separates true bit-wise set and clear from a whole-word overwrite. Pins are toggled with only rise enabled, only fall enabled, both enabled and neither enabled, which shows that each enable gates only its own transition. One edge is timed to land in the same cycle as its clear, to show that no edge is lost. A random run of bus accesses, including unmapped addresses, and pin toggles is compared every cycle against a behavioural model. Reads issued one, two and three edges after a pin change fix the synchronizer latency.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int WORD_W = 32;

  // group order fixes the address map
  typedef enum logic [2:0] {
    F_LEVEL = 3'd0,
    F_DIR   = 3'd1,
    F_SET   = 3'd2,
    F_CLR   = 3'd3,
    F_RISE  = 3'd4,
    F_FALL  = 3'd5,
    F_STAT  = 3'd6,
    F_ALT   = 3'd7
  } feat_e;
endpackage

// File: rtl/gpio_bank_decode.sv
`timescale 1ns/1ps
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NREG   = 2,
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output feat_e             feat_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int ALT_BASE  = 7 * NREG;
  localparam int ALT_WORDS = 2 * NREG;

  always_comb begin
    hit_o  = 1'b0;
    feat_o = F_LEVEL;
    idx_o  = '0;
    for (int g = 0; g < 7; g++) begin
      if (int'(addr_i) >= g * NREG && int'(addr_i) < (g + 1) * NREG) begin
        hit_o  = 1'b1;
        feat_o = feat_e'(g);
        idx_o  = IDX_W'(int'(addr_i) - g * NREG);
      end
    end
    if (int'(addr_i) >= ALT_BASE && int'(addr_i) < ALT_BASE + ALT_WORDS) begin
      hit_o  = 1'b1;
      feat_o = F_ALT;
      idx_o  = IDX_W'(int'(addr_i) - ALT_BASE);
    end
  end
endmodule

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_edge.sv
`timescale 1ns/1ps
module gpio_bank_edge #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] prev_q, stat_q, hit;

  assign hit = (lvl_i & ~prev_q & rise_en_i) | (~lvl_i & prev_q & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // new edge wins over a clear in the same cycle
      stat_q <= (stat_q & ~clr_i) | hit;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter  int NUM_PINS = 64,
  localparam int NREG     = NUM_PINS / 32,
  localparam int ADDR_W   = $clog2(9 * NREG)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   pin_o,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [2*NUM_PINS-1:0] alt_fn_o,
  output logic                  irq_o
);
  localparam int ALT_WORDS = 2 * NREG;
  localparam int IDX_W     = $clog2(ALT_WORDS);

  logic                  hit;
  feat_e                 feat;
  logic [IDX_W-1:0]      idx;
  logic                  wr, rd;
  logic [NUM_PINS-1:0]   lvl, stat, stat_clr;
  logic [NUM_PINS-1:0]   dir_q, out_q, rise_q, fall_q;
  logic [2*NUM_PINS-1:0] alt_q;
  logic [31:0]           rd_word, rdata_q;

  gpio_bank_decode #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_decode (
    .addr_i (addr_i),
    .hit_o  (hit),
    .feat_o (feat),
    .idx_o  (idx)
  );

  gpio_bank_sync #(.W(NUM_PINS), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (lvl)
  );

  gpio_bank_edge #(.W(NUM_PINS)) i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .clr_i     (stat_clr),
    .stat_o    (stat)
  );

  assign wr = req_i & we_i & hit;
  assign rd = req_i & ~we_i;

  always_comb begin
    stat_clr = '0;
    if (wr && feat == F_STAT) stat_clr[int'(idx)*32 +: 32] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      alt_q  <= '0;
    end else begin
      for (int w = 0; w < NREG; w++) begin
        if (wr && int'(idx) == w) begin
          case (feat)
            F_DIR:   dir_q[w*32 +: 32]  <= wdata_i;
            F_SET:   out_q[w*32 +: 32]  <= out_q[w*32 +: 32] | wdata_i;
            F_CLR:   out_q[w*32 +: 32]  <= out_q[w*32 +: 32] & ~wdata_i;
            F_RISE:  rise_q[w*32 +: 32] <= wdata_i;
            F_FALL:  fall_q[w*32 +: 32] <= wdata_i;
            default: ;
          endcase
        end
      end
      for (int w = 0; w < ALT_WORDS; w++) begin
        if (wr && feat == F_ALT && int'(idx) == w) alt_q[w*32 +: 32] <= wdata_i;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit) begin
      case (feat)
        F_LEVEL: rd_word = lvl[int'(idx)*32 +: 32];
        F_DIR:   rd_word = dir_q[int'(idx)*32 +: 32];
        F_RISE:  rd_word = rise_q[int'(idx)*32 +: 32];
        F_FALL:  rd_word = fall_q[int'(idx)*32 +: 32];
        F_STAT:  rd_word = stat[int'(idx)*32 +: 32];
        F_ALT:   rd_word = alt_q[int'(idx)*32 +: 32];
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_word;
  end

  assign rdata_o  = rdata_q;
  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign alt_fn_o = alt_q;
  assign irq_o    = |stat;
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
  parameter  int NUM_PINS = 64,
  localparam int NREG     = NUM_PINS / 32,
  localparam int ADDR_W   = $clog2(9 * NREG)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [31:0]           wdata_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_PINS-1:0]   pin_i,
  input logic [NUM_PINS-1:0]   pin_o,
  input logic [NUM_PINS-1:0]   pin_oe_o,
  input logic [2*NUM_PINS-1:0] alt_fn_o,
  input logic                  irq_o
);
  localparam logic [ADDR_W-1:0] SET0 = ADDR_W'(2 * NREG);
  localparam logic [ADDR_W-1:0] CLR0 = ADDR_W'(3 * NREG);

  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(pin_oe_o)); // R3

  AST_SET_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == SET0 |=> (pin_o[31:0] & $past(wdata_i)) == $past(wdata_i)); // R4

  AST_CLR_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == CLR0 |=> (pin_o[31:0] & $past(wdata_i)) == 32'd0); // R4

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(pin_o)); // R4

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(req_i && we_i) |=> irq_o); // R7

  AST_ALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(alt_fn_o)); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_i == $past(pin_i) && $past(pin_i) == $past(pin_i, 2) &&
     $past(pin_i, 2) == $past(pin_i, 3) && $past(pin_i, 3) == $past(pin_i, 4))
    |-> !$rose(irq_o)); // R9

  AST_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && (addr_i == SET0 || addr_i == CLR0) |=> rdata_o == 32'd0); // R10
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) i_chk (.*);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  localparam int N      = 64;
  localparam int NREG   = N / 32;
  localparam int ADDR_W = $clog2(9 * NREG);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [N-1:0]      pin = '0;
  logic [N-1:0]      pin_o, pin_oe;
  logic [2*N-1:0]    alt_fn;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  logic [N-1:0]   m_s1, m_s2, m_prev, m_dir, m_out, m_rise, m_fall, m_stat;
  logic [2*N-1:0] m_alt;
  logic [31:0]    m_rd;

  always #10 clk = ~clk;

  gpio_bank #(.NUM_PINS(N)) i_gpio_bank (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .req_i    (req),
    .we_i     (we),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pin_i    (pin),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe),
    .alt_fn_o (alt_fn),
    .irq_o    (irq)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_dir = '0; m_out = '0;
    m_rise = '0; m_fall = '0; m_stat = '0; m_alt = '0; m_rd = '0;
  endtask

  task automatic model_tick();
    logic [N-1:0] hit, clr;
    int a, f, i;
    bit ok;
    hit = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
    clr = '0;
    a = int'(addr);
    ok = 1; f = 0; i = 0;
    if (a < 7 * NREG) begin f = a / NREG; i = a % NREG; end
    else if (a < 9 * NREG) begin f = 7; i = a - 7 * NREG; end
    else ok = 0;
    if (req && !we) begin
      m_rd = '0;
      if (ok) begin
        case (f)
          0: m_rd = m_s2[i*32 +: 32];
          1: m_rd = m_dir[i*32 +: 32];
          4: m_rd = m_rise[i*32 +: 32];
          5: m_rd = m_fall[i*32 +: 32];
          6: m_rd = m_stat[i*32 +: 32];
          7: m_rd = m_alt[i*32 +: 32];
          default: m_rd = '0;
        endcase
      end
    end
    if (req && we && ok) begin
      case (f)
        1: m_dir[i*32 +: 32]  = wdata;
        2: m_out[i*32 +: 32]  = m_out[i*32 +: 32] | wdata;
        3: m_out[i*32 +: 32]  = m_out[i*32 +: 32] & ~wdata;
        4: m_rise[i*32 +: 32] = wdata;
        5: m_fall[i*32 +: 32] = wdata;
        6: clr[i*32 +: 32]    = wdata;
        7: m_alt[i*32 +: 32]  = wdata;
        default: ;
      endcase
    end
    m_stat = (m_stat & ~clr) | hit;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pin;
  endtask

  task automatic compare_all();
    chk("R4 pin_o", 128'(pin_o), 128'(m_out));
    chk("R3 pin_oe_o", 128'(pin_oe), 128'(m_dir));
    chk("R8 alt_fn_o", 128'(alt_fn), 128'(m_alt));
    chk("R9 irq_o", 128'(irq), 128'(|m_stat));
    chk("R2 rdata_o", 128'(rdata), 128'(m_rd));
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic r, input logic w, input int a, input logic [31:0] d);
    req = r; we = w; addr = ADDR_W'(a); wdata = d;
    @(posedge clk);
    model_tick();
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 0, 32'd0);
  endtask

  task automatic wr_word(input int a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d);
  endtask

  task automatic rd_word(input int a);
    step(1'b1, 1'b0, a, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 pin_oe_o", 128'(pin_oe), 128'd0);
    chk("R1 pin_o", 128'(pin_o), 128'd0);
    chk("R1 alt_fn_o", 128'(alt_fn), 128'd0);
    chk("R1 irq_o", 128'(irq), 128'd0);
    rd_word(6 * NREG);
    chk("R1 status", 128'(rdata), 128'd0);

    // R3 / R2 direction word 1
    wr_word(NREG + 1, 32'hF0F0_0000);
    chk("R3 oe upper", 128'(pin_oe[63:32]), 128'h F0F0_0000);
    chk("R3 oe lower", 128'(pin_oe[31:0]), 128'd0);
    rd_word(NREG + 1);
    chk("R2 dir readback", 128'(rdata), 128'h F0F0_0000);

    // R4 set/clear
    wr_word(2 * NREG, 32'h0000_00FF);
    wr_word(2 * NREG, 32'h0000_0F00);
    chk("R4 set accumulates", 128'(pin_o[31:0]), 128'h0FFF);
    wr_word(3 * NREG, 32'h0000_000F);
    chk("R4 clear bits", 128'(pin_o[31:0]), 128'h0FF0);
    wr_word(2 * NREG + 1, 32'h0000_0001);
    chk("R2 set word1 pin32", 128'(pin_o[32]), 128'd1);
    chk("R2 set word1 keeps word0", 128'(pin_o[31:0]), 128'h0FF0);

    // R10 ignored writes and zero reads
    rd_word(2 * NREG);
    chk("R10 set reads zero", 128'(rdata), 128'd0);
    rd_word(3 * NREG + 1);
    chk("R10 clear reads zero", 128'(rdata), 128'd0);
    wr_word(0, 32'hFFFF_FFFF);
    rd_word(0);
    chk("R10 level write ignored", 128'(rdata), 128'd0);

    // R5 level sampling
    pin = 64'hA5A5_0000_1234_5678;
    idle(3);
    rd_word(1);
    chk("R5 level word1", 128'(rdata), 128'h A5A5_0000);
    rd_word(0);
    chk("R5 level word0", 128'(rdata), 128'h1234_5678);
    chk("R6 no enable no status", 128'(irq), 128'd0);
    pin[31:0] = 32'hFFFF_0000;
    rd_word(0);
    chk("R5 edge1 old", 128'(rdata), 128'h1234_5678);
    rd_word(0);
    chk("R5 edge2 old", 128'(rdata), 128'h1234_5678);
    rd_word(0);
    chk("R5 edge3 new", 128'(rdata), 128'h FFFF_0000);

    // R6 rise enable on pin 3
    wr_word(4 * NREG, 32'h0000_0008);
    pin[3] = 1'b1;
    idle(4);
    rd_word(6 * NREG);
    chk("R6 rise status", 128'(rdata), 128'h8);
    chk("R9 irq high", 128'(irq), 128'd1);
    pin[3] = 1'b0;
    idle(4);
    wr_word(6 * NREG, 32'h0000_0008);
    chk("R7 cleared irq low", 128'(irq), 128'd0);
    rd_word(6 * NREG);
    chk("R6 fall not enabled", 128'(rdata), 128'd0);

    // R6 both edges on pin 40, R7 simultaneous clear
    wr_word(4 * NREG + 1, 32'h0000_0100);
    wr_word(5 * NREG + 1, 32'h0000_0100);
    pin[40] = 1'b1;
    idle(4);
    rd_word(6 * NREG + 1);
    chk("R6 both rise", 128'(rdata), 128'h100);
    pin[40] = 1'b0;
    idle(2);
    wr_word(6 * NREG + 1, 32'h0000_0100);
    rd_word(6 * NREG + 1);
    chk("R7 edge kept over clear", 128'(rdata), 128'h100);
    wr_word(6 * NREG + 1, 32'h0000_0100);
    rd_word(6 * NREG + 1);
    chk("R7 clear by one", 128'(rdata), 128'd0);
    chk("R9 irq low", 128'(irq), 128'd0);

    // R8 function code of pin 33
    wr_word(7 * NREG + 2, 32'h0000_000C);
    chk("R8 pin33 code", 128'(alt_fn[67:66]), 128'd3);
    chk("R8 pin32 code", 128'(alt_fn[65:64]), 128'd0);
    rd_word(7 * NREG + 2);
    chk("R2 alt readback", 128'(rdata), 128'hC);

    // random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      if ($urandom % 8 == 0) pin = {$urandom, $urandom};
      step(($urandom % 3) != 0, ($urandom % 2) != 0,
           int'($urandom % (9 * NREG + 3)), $urandom);
    end

    // R9 quiet pins: clear and stay low
    idle(5);
    wr_word(6 * NREG, 32'hFFFF_FFFF);
    wr_word(6 * NREG + 1, 32'hFFFF_FFFF);
    idle(4);
    chk("R9 quiet irq", 128'(irq), 128'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule